// File: doc/BRIEF.md
# I2C 16-bit Register Write Master

This block is a bit-level I2C master that performs one register write into a peripheral chip per request. The caller presents an 8-bit register index and a 16-bit value together with a one-cycle request. The block then runs a complete bus transaction on its own. It sends a START, then the device address byte with the write bit, then the register index, the upper data byte and the lower data byte, and it ends with a STOP. An acknowledge is sampled after every byte.

SCL is driven push-pull, since clock stretching is not supported. SDA is open-drain: the block only ever pulls the line low through an output-enable and reads the resolved line back on a separate input. The SCL phase lengths and the START and STOP setup intervals are counted in system clocks. These counts are derived from clock-frequency parameters, so the bus keeps standard-mode timing whatever the system clock is. When the STOP finishes, a one-cycle done pulse is given. An error flag reports whether any byte went unacknowledged, and it stays set until the next request is taken.

Top module: `i2c_reg16_writer`

## Requirements
- R1: After reset, and whenever the block is idle, SCL is high, SDA is released (`sda_oe_o` = 0), and `busy_o`, `done_o` and `err_o` are low.
- R2: Each transaction sends exactly four bytes in this order: the device byte 0x5C (7-bit address 0x2E shifted left, with write bit 0), the register index, data bits 15:8, then data bits 7:0. A request is latched only in the cycle it is accepted.
- R3: Bits go out most-significant first. SDA changes only while SCL is low, except for the single START and the single STOP of each transaction.
- R4: During the ninth clock of every byte, the master releases SDA (`sda_oe_o` = 0) and samples the line at the end of the SCL high phase. A low line is an acknowledge.
- R5: A high line in any acknowledge slot sets `err_o`. The flag stays set for the rest of the transaction and while the block is idle. It clears in the cycle the next request is accepted.
- R6: `busy_o` rises one cycle after a request is accepted and stays high until the STOP completes. A request seen while busy is ignored: it does not alter the bytes in flight and does not start another transaction.
- R7: Every SCL high phase between START and STOP, including the one that follows the START, lasts CLK_HZ/(2*SCL_HZ) system clocks.
- R8: SCL and SDA are both high for at least ceil(CLK_HZ * 4.7 us) clocks before SDA falls for START. SCL is high for at least ceil(CLK_HZ * 4.0 us) clocks before SDA rises for STOP. The transaction always ends with a STOP, even after a NACK.
- R9: `done_o` is a one-cycle pulse in the first cycle where `busy_o` is low after the STOP. `err_o` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Start a register write (taken only when idle) |
| reg_addr_i | input | 8 | Register index to write |
| reg_data_i | input | 16 | Register value, upper byte sent first |
| scl_o | output | 1 | Bus clock, driven push-pull |
| sda_oe_o | output | 1 | Pull SDA low when 1, release when 0 |
| sda_i | input | 1 | Resolved SDA line level |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse when STOP completes |
| err_o | output | 1 | Sticky flag: some byte was not acknowledged |

## Verification
The assertions take the resolved SDA level on `sda_i` to be settled and synchronous to `clk` at the sampling edge. That is why the acknowledge check and the stable-while-high property make no allowance for metastability or bus noise. They also take it that the far device never holds SCL and never drives SDA except during an acknowledge slot. The stimulus respects both conditions. The device model on the bench updates its pull-down only half a clock away from the sampling edge. It pulls SDA only after the eighth falling SCL edge of a byte and lets go on the following falling edge. Requests are pulsed for a single cycle, and the register index and data only need to be valid in the cycle they are accepted.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    // Frame layout: device byte, register index, then the data bytes.
    localparam int unsigned DATA_BYTES  = 2;
    localparam int unsigned FRAME_BYTES = DATA_BYTES + 2;
    localparam int unsigned IDX_W       = $clog2(FRAME_BYTES);
    localparam int unsigned WORD_W      = 8 * DATA_BYTES;

    // Standard-mode setup minimums in nanoseconds.
    localparam longint unsigned T_STA_SETUP_NS = 4700;
    localparam longint unsigned T_STO_SETUP_NS = 4000;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_STA_SU,
        PH_STA_HD,
        PH_BIT_LO,
        PH_BIT_HI,
        PH_STO_LO,
        PH_STO_SU,
        PH_STO_BUF
    } phase_e;

    typedef struct packed {
        logic [7:0]        index;
        logic [WORD_W-1:0] value;
    } wr_cmd_t;

    // Round a duration up to whole system clocks, never below one.
    function automatic int unsigned ns_to_clocks(longint unsigned clk_hz,
                                                 longint unsigned ns);
        longint unsigned prod;
        longint unsigned cyc;
        prod = clk_hz * ns;
        cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
        if (cyc == 0) cyc = 1;
        return int'(cyc);
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b,
                                         int unsigned c);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/i2cw_timer.sv
module i2cw_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [TW-1:0] len_i,
    output logic          expire_o
);

    logic [TW-1:0] cnt_q;

    // A load of len makes the current interval last exactly len cycles.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_i - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = (cnt_q == '0);

    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
        load_i |-> (len_i != '0)); // R7

endmodule

// File: rtl/i2cw_frame.sv
module i2cw_frame
    import i2cw_pkg::*;
#(
    parameter logic [6:0] SLAVE_ID = 7'h2E
) (
    input  wr_cmd_t          cmd_i,
    input  logic [IDX_W-1:0] byte_sel_i,
    input  logic [2:0]       bit_sel_i,
    output logic             bit_o
);

    logic [7:0] frame_bytes [FRAME_BYTES];
    logic [7:0] cur_byte;

    assign frame_bytes[0] = {SLAVE_ID, 1'b0};
    assign frame_bytes[1] = cmd_i.index;

    // Data bytes follow the index, most significant byte first.
    for (genvar k = 0; k < DATA_BYTES; k++) begin : g_data
        assign frame_bytes[2+k] = cmd_i.value[8*(DATA_BYTES-1-k) +: 8];
    end

    assign cur_byte = frame_bytes[byte_sel_i];
    assign bit_o    = cur_byte[3'd7 - bit_sel_i];

endmodule

// File: rtl/i2cw_ctrl.sv
module i2cw_ctrl
    import i2cw_pkg::*;
#(
    parameter int unsigned HALF_CYC = 250,
    parameter int unsigned STA_CYC  = 235,
    parameter int unsigned STO_CYC  = 200,
    parameter int unsigned TW       = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    input  logic             bit_i,
    input  logic             sda_i,
    input  logic             expire_i,
    output logic             load_o,
    output logic [TW-1:0]    len_o,
    output logic [IDX_W-1:0] byte_sel_o,
    output logic [2:0]       bit_sel_o,
    output logic             accept_o,
    output logic             scl_o,
    output logic             sda_oe_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o
);

    localparam logic [TW-1:0]    LEN_HALF  = TW'(HALF_CYC);
    localparam logic [TW-1:0]    LEN_STA   = TW'(STA_CYC);
    localparam logic [TW-1:0]    LEN_STO   = TW'(STO_CYC);
    localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(FRAME_BYTES - 1);
    localparam logic [3:0]       ACK_SLOT  = 4'd8;

    phase_e           state_q, state_d;
    logic [3:0]       bit_q, bit_d;
    logic [IDX_W-1:0] byte_q, byte_d;
    logic             err_q, done_q;
    logic             ack_end;
    logic             in_bit;

    assign accept_o = (state_q == PH_IDLE) && req_i;
    assign in_bit   = (state_q == PH_BIT_LO) || (state_q == PH_BIT_HI);
    assign ack_end  = (state_q == PH_BIT_HI) && expire_i && (bit_q == ACK_SLOT);

    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        byte_d  = byte_q;
        load_o  = 1'b0;
        len_o   = LEN_HALF;
        unique case (state_q)
            PH_IDLE: begin
                if (req_i) begin
                    state_d = PH_STA_SU;
                    load_o  = 1'b1;
                    len_o   = LEN_STA;
                end
            end
            PH_STA_SU: begin
                if (expire_i) begin
                    state_d = PH_STA_HD;
                    load_o  = 1'b1;
                end
            end
            PH_STA_HD: begin
                if (expire_i) begin
                    state_d = PH_BIT_LO;
                    load_o  = 1'b1;
                    bit_d   = '0;
                    byte_d  = '0;
                end
            end
            PH_BIT_LO: begin
                if (expire_i) begin
                    state_d = PH_BIT_HI;
                    load_o  = 1'b1;
                end
            end
            PH_BIT_HI: begin
                if (expire_i) begin
                    load_o = 1'b1;
                    if (bit_q == ACK_SLOT) begin
                        if (byte_q == LAST_BYTE) begin
                            state_d = PH_STO_LO;
                        end else begin
                            state_d = PH_BIT_LO;
                            byte_d  = byte_q + 1'b1;
                            bit_d   = '0;
                        end
                    end else begin
                        state_d = PH_BIT_LO;
                        bit_d   = bit_q + 1'b1;
                    end
                end
            end
            PH_STO_LO: begin
                if (expire_i) begin
                    state_d = PH_STO_SU;
                    load_o  = 1'b1;
                    len_o   = LEN_STO;
                end
            end
            PH_STO_SU: begin
                if (expire_i) begin
                    state_d = PH_STO_BUF;
                    load_o  = 1'b1;
                end
            end
            PH_STO_BUF: begin
                if (expire_i) begin
                    state_d = PH_IDLE;
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
            bit_q   <= '0;
            byte_q  <= '0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
            byte_q  <= byte_d;
            done_q  <= (state_q == PH_STO_BUF) && expire_i;
            if (accept_o) begin
                err_q <= 1'b0;
            end else if (ack_end && sda_i) begin
                err_q <= 1'b1;
            end
        end
    end

    // Line decode: SCL low only in data-low and stop-low phases.
    assign scl_o    = !((state_q == PH_BIT_LO) || (state_q == PH_STO_LO));
    assign sda_oe_o = (state_q == PH_STA_HD) || (state_q == PH_STO_LO) ||
                      (state_q == PH_STO_SU) ||
                      (in_bit && (bit_q != ACK_SLOT) && !bit_i);

    assign byte_sel_o = byte_q;
    assign bit_sel_o  = bit_q[2:0];
    assign busy_o     = (state_q != PH_IDLE);
    assign done_o     = done_q;
    assign err_o      = err_q;

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (scl_o && !sda_oe_o)); // R1

    AST_SDA_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_BIT_HI && $past(state_q) == PH_BIT_HI) |-> $stable(sda_oe_o)); // R3

    AST_ACK_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (scl_o && in_bit && bit_q == ACK_SLOT) |-> !sda_oe_o); // R4

    AST_ERR_AT_ACK: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> ($past(state_q) == PH_BIT_HI && $past(bit_q) == ACK_SLOT)); // R5

    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> !err_o); // R5

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (scl_o && !sda_oe_o && $past(state_q) == PH_STO_BUF)); // R8

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o))); // R9

endmodule

// File: rtl/i2c_reg16_writer.sv
module i2c_reg16_writer
    import i2cw_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 50_000_000,
    parameter int unsigned SCL_HZ   = 100_000,
    parameter logic [6:0]  SLAVE_ID = 7'h2E
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_i,
    input  logic [7:0]  reg_addr_i,
    input  logic [15:0] reg_data_i,
    output logic        scl_o,
    output logic        sda_oe_o,
    input  logic        sda_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        err_o
);

    localparam int unsigned HALF_RAW = CLK_HZ / (2 * SCL_HZ);
    localparam int unsigned HALF_CYC = (HALF_RAW == 0) ? 1 : HALF_RAW;
    localparam int unsigned STA_CYC  = ns_to_clocks(longint'(CLK_HZ), T_STA_SETUP_NS);
    localparam int unsigned STO_CYC  = ns_to_clocks(longint'(CLK_HZ), T_STO_SETUP_NS);
    localparam int unsigned LONGEST  = max3(HALF_CYC, STA_CYC, STO_CYC);
    localparam int unsigned TW       = $clog2(LONGEST + 1);

    wr_cmd_t          cmd_q;
    logic             accept;
    logic             tmr_load;
    logic [TW-1:0]    tmr_len;
    logic             tmr_expire;
    logic [IDX_W-1:0] byte_sel;
    logic [2:0]       bit_sel;
    logic             cur_bit;

    // The request is captured only in its acceptance cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (accept) begin
            cmd_q <= '{index: reg_addr_i, value: reg_data_i};
        end
    end

    i2cw_timer #(
        .TW (TW)
    ) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load_i   (tmr_load),
        .len_i    (tmr_len),
        .expire_o (tmr_expire)
    );

    i2cw_frame #(
        .SLAVE_ID (SLAVE_ID)
    ) i_frame (
        .cmd_i      (cmd_q),
        .byte_sel_i (byte_sel),
        .bit_sel_i  (bit_sel),
        .bit_o      (cur_bit)
    );

    i2cw_ctrl #(
        .HALF_CYC (HALF_CYC),
        .STA_CYC  (STA_CYC),
        .STO_CYC  (STO_CYC),
        .TW       (TW)
    ) i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req_i),
        .bit_i      (cur_bit),
        .sda_i      (sda_i),
        .expire_i   (tmr_expire),
        .load_o     (tmr_load),
        .len_o      (tmr_len),
        .byte_sel_o (byte_sel),
        .bit_sel_o  (bit_sel),
        .accept_o   (accept),
        .scl_o      (scl_o),
        .sda_oe_o   (sda_oe_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .err_o      (err_o)
    );

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(cmd_q)); // R6

endmodule

// File: tb/test_i2c_reg16_writer.sv
module test_i2c_reg16_writer;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 4_000_000;
    localparam int SCL_HZ     = 100_000;
    localparam int HALF_EXP   = CLK_HZ / (2 * SCL_HZ);
    localparam int STA_MIN    = ((CLK_HZ / 1000) * 4700 + 999_999) / 1_000_000;
    localparam int STO_MIN    = ((CLK_HZ / 1000) * 4000 + 999_999) / 1_000_000;
    localparam int WATCHDOG   = 150_000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_data = '0;
    logic        scl, m_oe, busy, done, err;
    logic        s_oe = 1'b0;
    logic        sda_line;

    assign sda_line = !(m_oe || s_oe);

    i2c_reg16_writer #(
        .CLK_HZ (CLK_HZ),
        .SCL_HZ (SCL_HZ)
    ) i_i2c_reg16_writer (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req),
        .reg_addr_i (reg_addr),
        .reg_data_i (reg_data),
        .scl_o      (scl),
        .sda_oe_o   (m_oe),
        .sda_i      (sda_line),
        .busy_o     (busy),
        .done_o     (done),
        .err_o      (err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int   n_checks = 0;
    int   n_errs   = 0;
    logic [7:0] exp_q [$];
    int   nack_at  = -1;
    int   frames_seen = 0;
    bit   finished = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor and device model, evaluated half a clock after the design's edge.
    logic       prev_scl = 1'b1;
    logic       prev_sda = 1'b1;
    int         hi_cnt   = 0;
    int         idle_cnt = 0;
    int         bitc     = 0;
    int         byte_i   = 0;
    bit         acking   = 1'b0;
    bit         in_frame = 1'b0;
    logic [7:0] shreg    = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (scl && prev_scl && prev_sda && !sda_line) begin
                check(idle_cnt >= STA_MIN, "R8", "start setup clocks", idle_cnt, STA_MIN);
                check(!in_frame, "R3", "start inside a frame", int'(in_frame), 0);
                in_frame = 1'b1;
                bitc     = 0;
                byte_i   = 0;
                acking   = 1'b0;
                hi_cnt   = 1;
            end else if (scl && prev_scl && !prev_sda && sda_line) begin
                check(hi_cnt >= STO_MIN, "R8", "stop setup clocks", hi_cnt, STO_MIN);
                check(byte_i == 4, "R2", "bytes in frame", byte_i, 4);
                check(exp_q.size() == 0, "R2", "unsent expected bytes", exp_q.size(), 0);
                check(in_frame, "R3", "stop outside a frame", int'(in_frame), 1);
                in_frame = 1'b0;
                frames_seen++;
            end else if (scl && !prev_scl) begin
                hi_cnt = 1;
                if (in_frame && !acking && bitc < 8) begin
                    shreg = {shreg[6:0], sda_line};
                    bitc++;
                end
            end else if (scl) begin
                hi_cnt++;
            end else if (!scl && prev_scl) begin
                check(hi_cnt == HALF_EXP, "R7", "scl high clocks", hi_cnt, HALF_EXP);
                hi_cnt = 0;
                if (in_frame) begin
                    if (acking) begin
                        s_oe   = 1'b0;
                        acking = 1'b0;
                        bitc   = 0;
                        byte_i++;
                    end else if (bitc == 8) begin
                        if (exp_q.size() == 0) begin
                            check(1'b0, "R2", "unexpected byte", int'(shreg), 0);
                        end else begin
                            logic [7:0] e;
                            e = exp_q.pop_front();
                            check(shreg == e, "R2", "frame byte", int'(shreg), int'(e));
                        end
                        s_oe   = (byte_i != nack_at);
                        acking = 1'b1;
                    end
                end
            end
            idle_cnt = (scl && sda_line) ? idle_cnt + 1 : 0;
            prev_scl = scl;
            prev_sda = sda_line;
        end
    end

    // Driver: push the expected bytes, issue the request, check the completion.
    task automatic write_reg(input logic [7:0] a, input logic [15:0] d,
                             input int nack, input bit poke);
        @(negedge clk);
        while (busy) @(negedge clk);
        exp_q.push_back(8'h5C);
        exp_q.push_back(a);
        exp_q.push_back(d[15:8]);
        exp_q.push_back(d[7:0]);
        nack_at  = nack;
        req      = 1'b1;
        reg_addr = a;
        reg_data = d;
        @(negedge clk);
        req      = 1'b0;
        reg_addr = ~a;
        reg_data = ~d;
        check(busy, "R6", "busy after accept", int'(busy), 1);
        check(!err, "R5", "error cleared on accept", int'(err), 0);
        if (poke) begin
            repeat (300) @(negedge clk);
            req      = 1'b1;
            reg_addr = 8'h77;
            reg_data = 16'hDEAD;
            @(negedge clk);
            req = 1'b0;
            check(busy, "R6", "busy during ignored request", int'(busy), 1);
        end
        while (!done) @(negedge clk);
        check(!busy, "R9", "busy low with done", int'(busy), 0);
        check(err == (nack >= 0), "R5", "error flag at done", int'(err), int'(nack >= 0));
        @(negedge clk);
        check(!done, "R9", "done lasts one cycle", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(scl, "R1", "scl after reset", int'(scl), 1);
        check(!m_oe, "R1", "sda released after reset", int'(m_oe), 0);
        check(!busy && !done && !err, "R1", "status after reset",
              int'({busy, done, err}), 0);

        write_reg(8'h29, 16'h00FF, -1, 1'b0);
        write_reg(8'hA5, 16'h5AC3, -1, 1'b1);
        repeat (100) @(negedge clk);
        check(!busy, "R6", "no transaction from ignored request", int'(busy), 0);
        check(frames_seen == 2, "R6", "frame count after ignored request", frames_seen, 2);

        write_reg(8'h3A, 16'hFFFF, 2, 1'b0);
        repeat (50) @(negedge clk);
        check(err, "R5", "error sticky while idle", int'(err), 1);
        check(scl && !m_oe, "R1", "idle lines after nack", int'({scl, m_oe}), 2);

        write_reg(8'h00, 16'h0000, 0, 1'b0);
        write_reg(8'h44, 16'h8001, -1, 1'b0);
        write_reg(8'h30, 16'h1234, 3, 1'b0);
        write_reg(8'hFF, 16'hA55A, -1, 1'b0);

        repeat (20) @(negedge clk);
        check(frames_seen == 7, "R8", "every transaction ended in stop", frames_seen, 7);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errs++;
            $display("FAIL R6 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

endmodule